// File: doc/BRIEF.md
# Dynamic 16-bit Bus Sizing Unit

This block sits between a core that issues 32-bit requests and an external bus whose devices may each be either 32 or 16 bits wide. The core presents one request at a time. It gives a doubleword address, four active-high byte enables, a direction and write data. The block then runs one or two external cycles and returns a one-clock completion pulse, together with the assembled read word.

The addressed device reports its width on every cycle through an active-low size input, which is sampled in the same clock as the active-low ready input. A 16-bit answer forces a second external cycle only when the request has active bytes in both halves of the word. In that second cycle the address stays the same, only the requested upper byte enables are driven, and the upper half of the data moves down onto lines 15..0. The active-low next-address input does not start a pipelined cycle here. Its only effect is on the size decision: once it has been accepted while the size input was inactive, 16-bit operation is locked out for the rest of that cycle.

Top module: `bus_sizer`

## Requirements
- R1: After reset, ads_no is 1, be_no is 4'b1111, done_o is 0 and req_ready_o is 1.
- R2: A request accepted (req_valid_i and req_ready_o high at a clock edge) makes ads_no low for exactly the next clock, with bus_addr_o equal to the request address and be_no equal to the inverted request byte enables.
- R3: If ready_ni and bs16_ni are both low in a data clock of the first cycle, and the request has a byte enable set in bits 1..0 and one set in bits 3..2, then ads_no goes low again in the next clock and done_o stays 0.
- R4: In the second cycle bus_addr_o keeps the first cycle's address, be_no[1:0] is 2'b11 and be_no[3:2] is the inverse of request bits 3..2.
- R5: In the second cycle of a write, bus_wdata_o[15:0] equals request write data bits 31..16. In the first cycle the full write word is driven.
- R6: For a split read, rdata_o[15:0] holds bus_rdata_i[15:0] from the first cycle's final clock, and rdata_o[31:16] holds bus_rdata_i[15:0] from the second cycle's final clock.
- R7: A 16-bit answer to a request whose byte enables lie entirely within one half completes in a single cycle.
- R8: If na_ni was low with bs16_ni high in an earlier data clock of the cycle, a later bs16_ni low at the final clock is ignored and the access completes as one 32-bit cycle.
- R9: bs16_ni low in the same clock as na_ni low, either before the final clock or in the final clock itself, still gives a 16-bit cycle.
- R10: ready_ni, bs16_ni and na_ni are ignored during the clock in which ads_no is low.
- R11: done_o is a single-clock pulse in the clock after the final ready. For a 32-bit read, rdata_o then equals the full bus_rdata_i word sampled in that final clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Core request valid |
| req_ready_o | output | 1 | Block idle, can take a request |
| req_addr_i | input | ADDR_W | Doubleword address of request |
| req_be_i | input | DATA_W/8 | Byte enables, active high |
| req_we_i | input | 1 | 1 = write |
| req_wdata_i | input | DATA_W | Write data |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | DATA_W | Assembled read data |
| ads_no | output | 1 | Address strobe, active low |
| bus_addr_o | output | ADDR_W | External address |
| be_no | output | DATA_W/8 | External byte enables, active low |
| bus_we_o | output | 1 | External direction |
| bus_wdata_o | output | DATA_W | External write data |
| bus_rdata_i | input | DATA_W | External read data |
| ready_ni | input | 1 | Cycle end, active low |
| bs16_ni | input | 1 | Device is 16 bits wide, active low |
| na_ni | input | 1 | Next-address request, active low |

## Verification
The hardest case to reach is the timing race between the next-address and size inputs inside one cycle. The outcome depends on which of them appears first, and on whether both appear in the same clock, before the final clock or in it. The directed tasks hold ready high for chosen wait clocks and drive each combination clock by clock, and a task also drives all three inputs low during the strobe clock to show that they are not sampled there. Every split case is then checked for the address staying put, the reduced byte enables, the shifted write data and the halves of the read word put back together.

// File: rtl/bsz_pkg.sv
package bsz_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bsz_state_e;
endpackage

// File: rtl/bsz_size_decide.sv
module bsz_size_decide #(
  parameter int NBE = 4
) (
  input  logic [NBE-1:0] be_i,
  input  logic           in_data_i,
  input  logic           ready_ni,
  input  logic           bs16_ni,
  input  logic           na_ni,
  input  logic           na_lock_i,
  output logic           need_split_o,
  output logic           take16_o,
  output logic           na_lock_set_o
);
  localparam int HALF = NBE / 2;

  // Split only when both halves carry bytes
  assign need_split_o  = (|be_i[HALF-1:0]) & (|be_i[NBE-1:HALF]);
  assign take16_o      = in_data_i & ~ready_ni & ~bs16_ni & ~na_lock_i;
  // NA taken without size indication locks 32-bit mode
  assign na_lock_set_o = in_data_i & ~na_ni & bs16_ni;
endmodule

// File: rtl/bsz_ctrl.sv
module bsz_ctrl
  import bsz_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_valid_i,
  input  logic       ready_ni,
  input  logic       take16_i,
  input  logic       need_split_i,
  input  logic       na_lock_set_i,
  output bsz_state_e state_o,
  output logic       second_o,
  output logic       na_lock_o,
  output logic       accept_o,
  output logic       cap_first_o,
  output logic       cap_second_o,
  output logic       done_o
);
  bsz_state_e state_q;
  logic second_q, na_lock_q, done_q;
  logic last_rdy, go_second;

  assign accept_o     = (state_q == ST_IDLE) & req_valid_i;
  assign last_rdy     = (state_q == ST_DATA) & ~ready_ni;
  assign cap_first_o  = last_rdy & ~second_q;
  assign cap_second_o = last_rdy & second_q;
  assign go_second    = cap_first_o & take16_i & need_split_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      second_q  <= 1'b0;
      na_lock_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      done_q <= last_rdy & ~go_second;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            state_q   <= ST_ADDR;
            na_lock_q <= 1'b0;
            second_q  <= 1'b0;
          end
        end
        ST_ADDR: state_q <= ST_DATA;
        ST_DATA: begin
          if (!ready_ni) begin
            na_lock_q <= 1'b0;
            if (go_second) begin
              state_q  <= ST_ADDR;
              second_q <= 1'b1;
            end else begin
              state_q  <= ST_IDLE;
              second_q <= 1'b0;
            end
          end else if (na_lock_set_i) begin
            na_lock_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o   = state_q;
  assign second_o  = second_q;
  assign na_lock_o = na_lock_q;
  assign done_o    = done_q;
endmodule

// File: rtl/bsz_lanes.sv
module bsz_lanes #(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              busy_i,
  input  logic              second_i,
  input  logic              cap_first_i,
  input  logic              cap_second_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W/8-1:0] be_q_o,
  output logic [DATA_W/8-1:0] be_no,
  output logic              bus_we_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int NBE   = DATA_W / 8;
  localparam int HBE   = NBE / 2;
  localparam int HDW   = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q;
  logic [NBE-1:0]    be_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      be_q    <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept_i) begin
        addr_q  <= req_addr_i;
        be_q    <= req_be_i;
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (cap_first_i)  rdata_q <= bus_rdata_i;
      if (cap_second_i) rdata_q[DATA_W-1:HDW] <= bus_rdata_i[HDW-1:0];
    end
  end

  always_comb begin
    if (!busy_i)       be_no = '1;
    else if (second_i) be_no = ~{be_q[NBE-1:HBE], {HBE{1'b0}}};
    else               be_no = ~be_q;
  end

  assign bus_wdata_o = second_i ? {2{wdata_q[DATA_W-1:HDW]}} : wdata_q;
  assign bus_addr_o  = addr_q;
  assign bus_we_o    = we_q;
  assign be_q_o      = be_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/bus_sizer.sv
module bus_sizer
  import bsz_pkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  output logic                req_ready_o,
  input  logic [ADDR_W-1:0]   req_addr_i,
  input  logic [DATA_W/8-1:0] req_be_i,
  input  logic                req_we_i,
  input  logic [DATA_W-1:0]   req_wdata_i,
  output logic                done_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                ads_no,
  output logic [ADDR_W-1:0]   bus_addr_o,
  output logic [DATA_W/8-1:0] be_no,
  output logic                bus_we_o,
  output logic [DATA_W-1:0]   bus_wdata_o,
  input  logic [DATA_W-1:0]   bus_rdata_i,
  input  logic                ready_ni,
  input  logic                bs16_ni,
  input  logic                na_ni
);
  localparam int NBE = DATA_W / 8;

  bsz_state_e     state;
  logic           second_q, na_lock, accept, cap_first, cap_second;
  logic           need_split, take16, na_lock_set;
  logic [NBE-1:0] be_q;

  bsz_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .ready_ni      (ready_ni),
    .take16_i      (take16),
    .need_split_i  (need_split),
    .na_lock_set_i (na_lock_set),
    .state_o       (state),
    .second_o      (second_q),
    .na_lock_o     (na_lock),
    .accept_o      (accept),
    .cap_first_o   (cap_first),
    .cap_second_o  (cap_second),
    .done_o        (done_o)
  );

  bsz_size_decide #(.NBE(NBE)) u_size (
    .be_i          (be_q),
    .in_data_i     (state == ST_DATA),
    .ready_ni      (ready_ni),
    .bs16_ni       (bs16_ni),
    .na_ni         (na_ni),
    .na_lock_i     (na_lock),
    .need_split_o  (need_split),
    .take16_o      (take16),
    .na_lock_set_o (na_lock_set)
  );

  bsz_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .busy_i       (state != ST_IDLE),
    .second_i     (second_q),
    .cap_first_i  (cap_first),
    .cap_second_i (cap_second),
    .req_addr_i   (req_addr_i),
    .req_be_i     (req_be_i),
    .req_we_i     (req_we_i),
    .req_wdata_i  (req_wdata_i),
    .bus_rdata_i  (bus_rdata_i),
    .bus_addr_o   (bus_addr_o),
    .be_q_o       (be_q),
    .be_no        (be_no),
    .bus_we_o     (bus_we_o),
    .bus_wdata_o  (bus_wdata_o),
    .rdata_o      (rdata_o)
  );

  assign req_ready_o = (state == ST_IDLE);
  assign ads_no      = ~(state == ST_ADDR);
endmodule

// File: rtl/bsz_checker.sv
module bsz_checker #(
  parameter int ADDR_W = 30,
  parameter int NBE    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              ads_no,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [NBE-1:0]    be_no,
  input logic              done_o,
  input logic              second_q
);
  localparam int HBE = NBE / 2;

  a_r2_ads_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ads_no |=> ads_no);

  a_r2_accept_ads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !ads_no);

  a_r4_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> (req_ready_o || $stable(bus_addr_o)));

  a_r4_second_upper_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (second_q && !ads_no) |-> (be_no[HBE-1:0] == {HBE{1'b1}}));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind bus_sizer bsz_checker #(.ADDR_W(ADDR_W), .NBE(DATA_W/8)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .ads_no      (ads_no),
  .bus_addr_o  (bus_addr_o),
  .be_no       (be_no),
  .done_o      (done_o),
  .second_q    (second_q)
);

// File: tb/tb_bus_sizer.sv
`timescale 1ns/1ps
module tb_bus_sizer;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [29:0] req_addr_i = '0;
  logic [3:0]  req_be_i = '0;
  logic [31:0] req_wdata_i = '0, bus_rdata_i = '0;
  logic        ready_ni = 1'b1, bs16_ni = 1'b1, na_ni = 1'b1;
  logic        req_ready_o, done_o, ads_no, bus_we_o;
  logic [31:0] rdata_o, bus_wdata_o;
  logic [29:0] bus_addr_o;
  logic [3:0]  be_no;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  bus_sizer dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [29:0] a, input logic [3:0] be, input logic we,
                       input logic [31:0] wd);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a; req_be_i = be; req_we_i = we; req_wdata_i = wd;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic bus_clk(input logic rdy, input logic bs, input logic na, input logic [31:0] rd);
    @(negedge clk_i);
    ready_ni = rdy; bs16_ni = bs; na_ni = na; bus_rdata_i = rd;
    @(posedge clk_i); #1;
    ready_ni = 1'b1; bs16_ni = 1'b1; na_ni = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 ads_no", 32'(ads_no), 32'd1);
    chk("R1 be_no", 32'(be_no), 32'hF);
    chk("R1 done_o", 32'(done_o), 32'd0);
    chk("R1 req_ready_o", 32'(req_ready_o), 32'd1);
  endtask

  task automatic t_rd32();
    issue(30'h0ABCDE, 4'hF, 1'b0, '0);
    chk("R2 ads low", 32'(ads_no), 32'd0);
    chk("R2 addr", 32'(bus_addr_o), 32'h0ABCDE);
    chk("R2 be_no", 32'(be_no), 32'h0);
    bus_clk(1, 1, 1, '0);
    chk("R2 ads one clock", 32'(ads_no), 32'd1);
    bus_clk(1, 1, 1, '0);
    chk("R11 no done in wait", 32'(done_o), 32'd0);
    bus_clk(0, 1, 1, 32'hA1B2C3D4);
    chk("R11 done", 32'(done_o), 32'd1);
    chk("R11 rdata", rdata_o, 32'hA1B2C3D4);
    @(posedge clk_i); #1;
    chk("R11 done pulse", 32'(done_o), 32'd0);
  endtask

  task automatic t_split_rd();
    issue(30'h001234, 4'hF, 1'b0, '0);
    bus_clk(1, 1, 1, '0);
    bus_clk(0, 0, 1, 32'hFFFF5678);
    chk("R3 second ads", 32'(ads_no), 32'd0);
    chk("R3 no done", 32'(done_o), 32'd0);
    chk("R4 addr kept", 32'(bus_addr_o), 32'h001234);
    chk("R4 be upper", 32'(be_no), 32'h3);
    bus_clk(1, 1, 1, '0);
    bus_clk(0, 1, 1, 32'hEEEE1234);
    chk("R6 done", 32'(done_o), 32'd1);
    chk("R6 rdata", rdata_o, 32'h12345678);
  endtask

  task automatic t_split_wr();
    issue(30'h000777, 4'b0110, 1'b1, 32'hCAFEBEEF);
    chk("R5 first wdata", bus_wdata_o, 32'hCAFEBEEF);
    bus_clk(1, 1, 1, '0);
    bus_clk(0, 0, 1, '0);
    chk("R5 second wdata low", 32'(bus_wdata_o[15:0]), 32'hCAFE);
    chk("R4 be requested upper", 32'(be_no), 32'hB);
    bus_clk(1, 1, 1, '0);
    bus_clk(0, 1, 1, '0);
    chk("R5 write done", 32'(done_o), 32'd1);
  endtask

  task automatic t_one_half(input logic [3:0] be);
    issue(30'h000010, be, 1'b0, '0);
    bus_clk(1, 1, 1, '0);
    bus_clk(0, 0, 1, 32'h0000BEEF);
    chk("R7 single cycle done", 32'(done_o), 32'd1);
    chk("R7 no second ads", 32'(ads_no), 32'd1);
  endtask

  task automatic t_na_lock();
    issue(30'h000020, 4'hF, 1'b0, '0);
    bus_clk(1, 1, 1, '0);
    bus_clk(1, 1, 0, '0);
    bus_clk(0, 0, 1, 32'h13572468);
    chk("R8 32-bit done", 32'(done_o), 32'd1);
    chk("R8 rdata", rdata_o, 32'h13572468);
  endtask

  task automatic t_na_same(input logic final_clk);
    issue(30'h000030, 4'hF, 1'b0, '0);
    bus_clk(1, 1, 1, '0);
    if (final_clk) bus_clk(0, 0, 0, '0);
    else begin
      bus_clk(1, 0, 0, '0);
      bus_clk(0, 0, 1, '0);
    end
    chk("R9 split ads", 32'(ads_no), 32'd0);
    chk("R9 no done", 32'(done_o), 32'd0);
    bus_clk(1, 1, 1, '0);
    bus_clk(0, 1, 1, '0);
    chk("R9 done", 32'(done_o), 32'd1);
  endtask

  task automatic t_ads_ignore();
    issue(30'h000040, 4'hF, 1'b0, '0);
    bus_clk(0, 1, 0, 32'h0);
    chk("R10 no done after ads clock", 32'(done_o), 32'd0);
    chk("R10 still busy", 32'(req_ready_o), 32'd0);
    bus_clk(0, 0, 1, 32'h0000AAAA);
    chk("R10 na ignored, split", 32'(ads_no), 32'd0);
    bus_clk(0, 0, 0, 32'h99990000);
    chk("R10 ready ignored in ads clock", 32'(done_o), 32'd0);
    bus_clk(0, 1, 1, 32'h00005555);
    chk("R10 done", 32'(done_o), 32'd1);
    chk("R10 rdata", rdata_o, 32'h5555AAAA);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    #9 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    t_reset();
    t_rd32();
    t_split_rd();
    t_split_wr();
    t_one_half(4'b0011);
    t_one_half(4'b1100);
    t_na_lock();
    t_na_same(1'b0);
    t_na_same(1'b1);
    t_ads_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule